// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers a set of level-sensitive interrupt request wires and steers each one, per processor core, onto one of fifteen output lines or onto none. Every core owns a private bank holding an enable mask and one four-bit routing code per input. All banks watch the same synchronized input levels. An output line of a bank is high while at least one input routed to it is both enabled and active in that bank.

Software reaches the banks through one 32-bit register port with byte addresses. Each bank takes a 32-byte window, and the bank number sits in the address bits above the window. Within a window the enable mask is at offset 0x00 and the read-only level register is at 0x04. The routing words sit at 0x08 through 0x14. These words run in descending input order, so the word at 0x08 serves the top eight inputs. Reads are combinational. Writes take effect at the clock edge.

Top module: `route_intc_top`

## Requirements
- R1: After reset every enable bit and every routing code is zero, all output lines are low, and reads of the mask and routing words return zero.
- R2: Offset 0x04 returns the input levels after a two-flop synchronizer, in the same way in every bank. A write to 0x04 changes nothing.
- R3: Offset 0x00 holds the enable mask of the addressed bank, one bit per input with input n at bit n, and reads back what was written.
- R4: The routing word at offset 0x08+4k holds the inputs (3-k)*8 to (3-k)*8+7. Input n uses bits [4*(n%8)+3 : 4*(n%8)], and each routing word reads back as written.
- R5: Routing code 0 connects the input to no line. Code c from 1 to 15 connects it to output line c-1.
- R6: Output line j of a bank is the OR, over all inputs i, of (enable bit i AND synchronized level i AND code i equal to j+1). A disabled input never drives a line.
- R7: A write to a mask or routing word shows on the output lines one clock edge after the write edge, and not before.
- R8: A write to one bank leaves the registers and output lines of every other bank unchanged.
- R9: A read of an unused offset, a misaligned address or a bank number at or above the core count returns zero. A write there changes no register.
- R10: Outputs follow input levels. A line falls three edges after its last active input falls (two synchronizer stages and one output register).

Bank k of core b is at byte address 32*b + offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Level interrupt inputs, asynchronous |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address: bank number in bits 7:5, offset in 4:0 |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, zero when no read hits a register |
| irqOut | output | 30 | Output lines, bank b at bits [15*b+14 : 15*b] |

## Verification
The bench builds the block with two cores, thirty-two inputs and fifteen lines. At this size the bench can try every input with every routing code in each bank. Each step checks the target line, the silence of the other bank and the readback of the routing word. Two banks are enough to show isolation, and the full code range reaches the top output line and the disconnected code. Pseudo-random mixes of masks, routes and levels then test the OR across many inputs against an arithmetic model. Directed cases cover the edge-by-edge latency of writes and falling levels.

// File: rtl/route_intc_pkg.sv
package route_intc_pkg;

  localparam int REG_W    = 32;
  localparam int CODE_W   = 4;
  localparam int PER_WORD = REG_W / CODE_W;
  localparam int WIN_LOG2 = 5;

  localparam int WORD_MASK   = 0;
  localparam int WORD_LEVEL  = 1;
  localparam int WORD_ROUTE0 = 2;

  typedef struct packed {
    logic             wrMask;
    logic             wrRoute;
    logic             rdMask;
    logic             rdLevel;
    logic             rdRoute;
    logic [7:0]       bank;
    logic [7:0]       routeIdx;
    logic [REG_W-1:0] data;
  } regStrobe_t;

endpackage

// File: rtl/route_intc_sync.sv
module route_intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/route_intc_ctrl.sv
module route_intc_ctrl
  import route_intc_pkg::*;
#(
  parameter int NUM_IN    = 32,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output regStrobe_t        stb,
  output logic              rdHit
);

  localparam int NUM_ROUTE = NUM_IN / PER_WORD;
  localparam int BANK_W    = ADDR_W - WIN_LOG2;

  logic [BANK_W-1:0] bankIdx;
  logic [2:0]        wordIdx;
  logic              aligned;
  logic              bankOk;
  logic              isMask;
  logic              isLevel;
  logic              isRoute;

  assign bankIdx = busAddr[ADDR_W-1:WIN_LOG2];
  assign wordIdx = busAddr[WIN_LOG2-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign bankOk  = (int'(bankIdx) < NUM_CORES);

  always_comb begin
    isMask  = aligned && bankOk && (int'(wordIdx) == WORD_MASK);
    isLevel = aligned && bankOk && (int'(wordIdx) == WORD_LEVEL);
    isRoute = aligned && bankOk && (int'(wordIdx) >= WORD_ROUTE0)
              && (int'(wordIdx) < WORD_ROUTE0 + NUM_ROUTE);
  end

  always_comb begin
    stb          = '0;
    stb.wrMask   = busWrEn && isMask;
    stb.wrRoute  = busWrEn && isRoute;
    stb.rdMask   = busRdEn && isMask;
    stb.rdLevel  = busRdEn && isLevel;
    stb.rdRoute  = busRdEn && isRoute;
    stb.bank     = {{(8-BANK_W){1'b0}}, bankIdx};
    stb.routeIdx = {5'd0, wordIdx} - 8'(WORD_ROUTE0);
    stb.data     = busWrData;
  end

  assign rdHit = stb.rdMask || stb.rdLevel || stb.rdRoute;

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrMask, stb.wrRoute, stb.rdMask, stb.rdLevel, stb.rdRoute})) else $error("strobe overlap"); // R9

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busWrEn && !busRdEn) |-> !(stb.wrMask || stb.wrRoute || rdHit)) else $error("strobe without access"); // R9

endmodule

// File: rtl/route_intc_bank.sv
module route_intc_bank
  import route_intc_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         stb,
  input  logic [NUM_IN-1:0]  level,
  output logic [REG_W-1:0]   rdWord,
  output logic [NUM_OUT-1:0] lineOut
);

  localparam int NUM_ROUTE = NUM_IN / PER_WORD;

  logic [NUM_IN-1:0]              maskQ;
  logic [NUM_IN-1:0][CODE_W-1:0]  routeQ;
  logic [NUM_OUT-1:0]             lineD;
  logic [NUM_OUT-1:0]             lineQ;
  logic                           mine;

  function automatic int wordOf(int n);
    return NUM_ROUTE - 1 - (n / PER_WORD);
  endfunction

  assign mine = (stb.bank == 8'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ <= '0;
    end else if (stb.wrMask && mine) begin
      maskQ <= stb.data[NUM_IN-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      routeQ <= '0;
    end else if (stb.wrRoute && mine) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (stb.routeIdx == 8'(wordOf(i)))
          routeQ[i] <= stb.data[CODE_W*(i%PER_WORD) +: CODE_W];
      end
    end
  end

  always_comb begin
    lineD = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (maskQ[i] && level[i] && (routeQ[i] == CODE_W'(o + 1)))
          lineD[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lineQ <= '0;
    else        lineQ <= lineD;
  end

  assign lineOut = lineQ;

  always_comb begin
    rdWord = '0;
    if (mine && stb.rdMask) begin
      rdWord[NUM_IN-1:0] = maskQ;
    end else if (mine && stb.rdRoute) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (stb.routeIdx == 8'(wordOf(i)))
          rdWord[CODE_W*(i%PER_WORD) +: CODE_W] = routeQ[i];
      end
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.wrMask && mine) |=> $stable(maskQ)) else $error("mask changed without write"); // R8

  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.wrRoute && mine) |=> $stable(routeQ)) else $error("route changed without write"); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ == '0) |=> (lineQ == '0)) else $error("line high with empty mask"); // R6

  AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (routeQ == '0) |=> (lineQ == '0)) else $error("line high with no route"); // R5

endmodule

// File: rtl/route_intc_top.sv
module route_intc_top
  import route_intc_pkg::*;
#(
  parameter int NUM_IN      = 32,
  parameter int NUM_OUT     = 15,
  parameter int NUM_CORES   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IN-1:0]            irqIn,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [REG_W-1:0]             busWrData,
  output logic [REG_W-1:0]             busRdData,
  output logic [NUM_CORES*NUM_OUT-1:0] irqOut
);

  localparam int MAX_OUT = (1 << CODE_W) - 1;

  initial begin
    if (NUM_OUT > MAX_OUT || NUM_IN % PER_WORD != 0 || NUM_IN > REG_W
        || ADDR_W <= WIN_LOG2 || ADDR_W > WIN_LOG2 + 8)
      $error("route_intc_top: unsupported parameters");
  end

  regStrobe_t              stb;
  logic                    rdHit;
  logic [NUM_IN-1:0]       level;
  logic [NUM_CORES-1:0][REG_W-1:0] bankRd;

  route_intc_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst_n(rst_n), .asyncIn(irqIn), .syncOut(level)
  );

  route_intc_ctrl #(.NUM_IN(NUM_IN), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .stb(stb), .rdHit(rdHit)
  );

  generate
    for (genvar b = 0; b < NUM_CORES; b++) begin : gBank
      route_intc_bank #(.IDX(b), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uBank (
        .clk(clk), .rst_n(rst_n), .stb(stb), .level(level),
        .rdWord(bankRd[b]), .lineOut(irqOut[b*NUM_OUT +: NUM_OUT])
      );
    end
  endgenerate

  always_comb begin
    busRdData = '0;
    if (stb.rdLevel) busRdData[NUM_IN-1:0] = level;
    for (int b = 0; b < NUM_CORES; b++) busRdData = busRdData | bankRd[b];
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && !rdHit) |-> (busRdData == '0)) else $error("unmapped read nonzero"); // R9

endmodule

// File: tb/tb_route_intc_top.sv
module tb_route_intc_top;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 32;
  localparam int NO = 15;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] irqIn = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NC*NO-1:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mMask [NC];
  int          mRoute [NC][NI];
  logic [31:0] seed = 32'h1badf00d;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_intc_top dut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [NO-1:0] expOut(int b, logic [NI-1:0] lv);
    logic [NO-1:0] r = '0;
    for (int i = 0; i < NI; i++)
      if (mMask[b][i] && lv[i] && mRoute[b][i] != 0) r[mRoute[b][i]-1] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] expWord(int b, int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'(mRoute[b][(3-k)*8 + j]);
    return w;
  endfunction

  function automatic logic [NO-1:0] outOf(int b);
    return irqOut[b*NO +: NO];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic progMask(input int b, input logic [31:0] m);
    wr(8'(b*32), m);
    mMask[b] = m;
  endtask

  task automatic progRoute(input int b, input int k, input logic [31:0] w);
    wr(8'(b*32 + 8 + 4*k), w);
    for (int j = 0; j < 8; j++) mRoute[b][(3-k)*8 + j] = int'(w[4*j +: 4]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NI-1:0] lv;
    for (int b = 0; b < NC; b++) begin
      mMask[b] = '0;
      for (int i = 0; i < NI; i++) mRoute[b][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", 32'(irqOut), 32'h0);
    for (int b = 0; b < NC; b++) begin
      rd(8'(b*32), d); chk("R1", d, 32'h0);
      for (int k = 0; k < 4; k++) begin rd(8'(b*32 + 8 + 4*k), d); chk("R1", d, 32'h0); end
    end

    // R5 R4 R8: every input, every code, each bank
    for (int b = 0; b < NC; b++) begin
      for (int i = 0; i < NI; i++) begin
        int k = 3 - i/8;
        progMask(b, 32'h1 << i);
        irqIn = NI'(1) << i;
        for (int c = 0; c < 16; c++) begin
          progRoute(b, k, 32'(c) << (4*(i%8)));
          settle();
          chk("R5", 32'(outOf(b)), 32'(expOut(b, irqIn)));
          chk("R8", 32'(outOf(1-b)), 32'(expOut(1-b, irqIn)));
          rd(8'(b*32 + 8 + 4*k), d);
          chk("R4", d, expWord(b, k));
        end
        progRoute(b, k, 32'h0);
      end
      progMask(b, 32'h0);
    end
    irqIn = '0;

    // R3: mask readback per bank
    progMask(0, 32'hA5C3_0F1E);
    progMask(1, 32'h5A3C_F0E1);
    rd(8'h00, d); chk("R3", d, 32'hA5C3_0F1E);
    rd(8'h20, d); chk("R3", d, 32'h5A3C_F0E1);

    // R6 R2 R4: mixed patterns against the model
    for (int n = 0; n < 40; n++) begin
      for (int b = 0; b < NC; b++) begin
        progMask(b, rnd());
        for (int k = 0; k < 4; k++) progRoute(b, k, rnd());
      end
      lv = rnd();
      irqIn = lv;
      settle();
      for (int b = 0; b < NC; b++) begin
        chk("R6", 32'(outOf(b)), 32'(expOut(b, lv)));
        rd(8'(b*32 + 4), d); chk("R2", d, lv);
        rd(8'(b*32 + 8 + 4*(n%4)), d); chk("R4", d, expWord(b, n%4));
      end
    end

    // R2: writing the level register changes nothing
    lv = 32'h00FF_1234;
    irqIn = lv;
    settle();
    wr(8'h04, ~lv);
    rd(8'h04, d); chk("R2", d, lv);
    rd(8'h00, d); chk("R2", d, mMask[0]);
    chk("R2", 32'(outOf(0)), 32'(expOut(0, lv)));

    // R7: write-to-output latency
    progMask(0, 32'h0);
    progMask(1, 32'h0);
    progRoute(0, 3, 32'h0000_5000);     // input 3 -> code 5 -> line 4
    irqIn = 32'h8;
    settle();
    chk("R7", 32'(outOf(0)), 32'h0);
    wr(8'h00, 32'h8);
    mMask[0] = 32'h8;
    chk("R7", 32'(outOf(0)), 32'h0);
    @(negedge clk);
    chk("R7", 32'(outOf(0)), 32'h10);

    // R10: level fall reaches the line after three edges
    irqIn = '0;
    repeat (2) @(negedge clk);
    chk("R10", 32'(outOf(0)), 32'h10);
    @(negedge clk);
    chk("R10", 32'(outOf(0)), 32'h0);

    // R9: unmapped offsets, misaligned and out-of-range banks
    irqIn = 32'hFFFF_FFFF;
    settle();
    rd(8'h18, d); chk("R9", d, 32'h0);
    rd(8'h1C, d); chk("R9", d, 32'h0);
    rd(8'h02, d); chk("R9", d, 32'h0);
    rd(8'h40, d); chk("R9", d, 32'h0);
    rd(8'hE8, d); chk("R9", d, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);
    for (int b = 0; b < NC; b++) begin
      rd(8'(b*32), d); chk("R9", d, mMask[b]);
      for (int k = 0; k < 4; k++) begin rd(8'(b*32 + 8 + 4*k), d); chk("R9", d, expWord(b, k)); end
    end
    settle();
    chk("R9", 32'(outOf(0)), 32'(expOut(0, irqIn)));
    chk("R9", 32'(outOf(1)), 32'(expOut(1, irqIn)));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule